// File: doc/BRIEF.md
# Tagged Receive/Transmit FIFO Data Register

This block sits behind a serial port's data register. On the transmit side, bus writes place bytes into an 8-deep transmit queue, and the serializer pops them from the other end. On the receive side, the deserializer pushes 11-bit entries into an 8-deep receive queue. Each entry holds a data byte and three per-entry tags: frame end, CRC mismatch and lost data. Bus reads pop the oldest receive byte. Only the byte is returned; the tags are not part of the read data.

The tags reach software through a status view instead. Whenever a different entry becomes the oldest one in the receive queue, its three tags are copied into the status outputs. They stay there until the next entry takes its place. If the deserializer pushes into a full receive queue, the new entry is dropped. The lost-data tag is then raised on the newest entry already stored. Each queue is held empty while its enable input is low.

Top module: `tagged_fifo_reg`

## Requirements
- R1: After reset, both queues are empty, neither full flag is set, and all three status bits are 0.
- R2: Bytes written with `bus_wr` while `tx_en` is 1 appear on `ser_tx_data` in write order. `ser_tx_pop` advances to the next byte. `ser_tx_data` is 0 while the transmit queue is empty.
- R3: Receive entries are laid out as: bits 7:0 data, bit 8 frame end, bit 9 CRC mismatch, bit 10 lost data. A bus read returns bits 7:0 of the oldest entry on `bus_rdata` in the same cycle and removes that entry. Entries come out in push order.
- R4: In the cycle after an entry becomes the oldest receive entry, `stat_eof`, `stat_crc` and `stat_ovr` equal its bits 8, 9 and 10. An entry becomes the oldest either by a push into an empty queue or by a pop that exposes it.
- R5: When a pop empties the receive queue, the status bits keep their last values. A read of an empty receive queue returns 0 and leaves the status bits unchanged.
- R6: Each queue holds 8 entries. `tx_full` or `rx_full` is 1 exactly when 8 entries are stored, and the empty flag is 1 exactly when none are. A write to a full transmit queue is dropped.
- R7: A receive push into a full queue is dropped and sets bit 10 of the newest stored entry. That tag reaches `stat_ovr` when that entry becomes the oldest.
- R8: While `tx_en` is 0, the transmit queue is emptied and writes are dropped. While `rx_en` is 0, the receive queue is emptied and pushes are dropped. The status bits are not cleared by either enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit queue enable; 0 holds it empty |
| rx_en | input | 1 | Receive queue enable; 0 holds it empty |
| bus_wr | input | 1 | Bus write strobe to the data register |
| bus_wdata | input | 8 | Byte to place into the transmit queue |
| bus_rd | input | 1 | Bus read strobe of the data register |
| bus_rdata | output | 8 | Oldest receive byte, 0 when empty |
| ser_tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| ser_tx_data | output | 8 | Oldest transmit byte, 0 when empty |
| tx_full | output | 1 | Transmit queue holds 8 entries |
| tx_empty | output | 1 | Transmit queue holds no entry |
| ser_rx_push | input | 1 | Deserializer pushes an entry |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_eof | input | 1 | Byte ends a frame |
| ser_rx_crc_err | input | 1 | Frame CRC did not match |
| rx_full | output | 1 | Receive queue holds 8 entries |
| rx_empty | output | 1 | Receive queue holds no entry |
| stat_eof | output | 1 | Frame-end tag of the current oldest entry |
| stat_crc | output | 1 | CRC-mismatch tag of the current oldest entry |
| stat_ovr | output | 1 | Lost-data tag of the current oldest entry |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that each strobe is a clean single-cycle level sampled at the rising edge. The bench meets both by changing every input only on the falling edge and by holding reset low for three edges. It drives pushes and pops in separate cycles, so the drop-on-full rule and the lost-data marking are exercised with no pop in the same cycle. Pushes also go into queues that are empty, partly filled and full, which produces both ways an entry can become the oldest.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
    localparam int BYTE_W  = 8;
    localparam int TAG_W   = 3;
    localparam int ENTRY_W = BYTE_W + TAG_W;

    // Tag order inside an entry, most significant first: lost data, CRC, frame end.
    typedef struct packed {
        logic ovr;
        logic crc;
        logic eof;
    } rx_tag_t;

    typedef struct packed {
        rx_tag_t               tag;
        logic [BYTE_W-1:0]     data;
    } rx_entry_t;
endpackage

// File: rtl/tfr_ring.sv
module tfr_ring #(
    parameter int W        = 8,
    parameter int DEPTH    = 8,
    parameter bit MARK_TOP = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic         head_load,
    output logic [W-1:0] nxt_head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } ring_t;

    ring_t q, d;
    logic  do_push, do_pop, overflow, mark_top;
    logic [AW-1:0] newest;

    function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    function automatic logic [AW-1:0] step_down(input logic [AW-1:0] p);
        return (p == '0) ? LAST : p - AW'(1);
    endfunction

    assign full     = (q.cnt == CW'(DEPTH));
    assign empty    = (q.cnt == '0);
    assign do_push  = en && push && !full;
    assign do_pop   = en && pop && !empty;
    assign overflow = en && push && full;
    assign newest   = step_down(q.wp);

    generate
        if (MARK_TOP) begin : g_mark
            assign mark_top = overflow;
        end else begin : g_nomark
            assign mark_top = 1'b0;
        end
    endgenerate

    always_comb begin
        d = q;
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp        = step_up(q.wp);
        end
        if (mark_top) begin
            d.mem[newest][W-1] = 1'b1;
        end
        if (do_pop) begin
            d.rp = step_up(q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
        if (!en) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end
    end

    // A different entry becomes the oldest on a pop that leaves data or on a push into empty.
    assign head_load = en && (d.cnt != '0) && (do_pop || (q.cnt == '0));
    assign nxt_head  = d.mem[d.rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R8
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> empty);

    // R7
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push && full && !pop) |=> full);
endmodule

// File: rtl/tfr_head.sv
module tfr_head #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] head
);
    logic [W-1:0] head_q, head_d;

    always_comb begin
        head_d = head_q;
        if (load) begin
            head_d = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else begin
            head_q <= head_d;
        end
    end

    assign head = head_q;

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(head_q));
endmodule

// File: rtl/tagged_fifo_reg.sv
module tagged_fifo_reg
    import tfr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ser_tx_pop,
    output logic [BYTE_W-1:0] ser_tx_data,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              ser_rx_push,
    input  logic [BYTE_W-1:0] ser_rx_data,
    input  logic              ser_rx_eof,
    input  logic              ser_rx_crc_err,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              stat_eof,
    output logic              stat_crc,
    output logic              stat_ovr
);
    logic              tx_load, rx_load;
    logic [BYTE_W-1:0] tx_nxt, tx_head;
    rx_entry_t         rx_in, rx_nxt, rx_head;

    assign rx_in.data    = ser_rx_data;
    assign rx_in.tag.eof = ser_rx_eof;
    assign rx_in.tag.crc = ser_rx_crc_err;
    assign rx_in.tag.ovr = 1'b0;

    tfr_ring #(.W(BYTE_W), .DEPTH(DEPTH), .MARK_TOP(1'b0)) u_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .push      (bus_wr),
        .wdata     (bus_wdata),
        .pop       (ser_tx_pop),
        .full      (tx_full),
        .empty     (tx_empty),
        .head_load (tx_load),
        .nxt_head  (tx_nxt)
    );

    tfr_head #(.W(BYTE_W)) u_tx_head (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_load),
        .nxt   (tx_nxt),
        .head  (tx_head)
    );

    tfr_ring #(.W(ENTRY_W), .DEPTH(DEPTH), .MARK_TOP(1'b1)) u_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .push      (ser_rx_push),
        .wdata     (rx_in),
        .pop       (bus_rd),
        .full      (rx_full),
        .empty     (rx_empty),
        .head_load (rx_load),
        .nxt_head  (rx_nxt)
    );

    // The oldest-entry register doubles as the tag status: it keeps its value when the queue drains.
    tfr_head #(.W(ENTRY_W)) u_rx_head (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rx_load),
        .nxt   (rx_nxt),
        .head  (rx_head)
    );

    assign ser_tx_data = tx_empty ? '0 : tx_head;
    assign bus_rdata   = (bus_rd && !rx_empty) ? rx_head.data : '0;
    assign stat_eof    = rx_head.tag.eof;
    assign stat_crc    = rx_head.tag.crc;
    assign stat_ovr    = rx_head.tag.ovr;

    initial begin
        // R6
        depth_chk: assert (DEPTH >= 2);
    end
endmodule

// File: tb/test_tagged_fifo_reg.sv
module test_tagged_fifo_reg;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, rx_en = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, ser_tx_pop = 1'b0, ser_rx_push = 1'b0;
    logic [7:0] bus_wdata = '0, ser_rx_data = '0;
    logic ser_rx_eof = 1'b0, ser_rx_crc_err = 1'b0;
    logic [7:0] bus_rdata, ser_tx_data;
    logic tx_full, tx_empty, rx_full, rx_empty, stat_eof, stat_crc, stat_ovr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  txq[$];
    logic [10:0] rxq[$];
    logic [2:0]  exp_stat = '0;

    always #(CLK_P/2) clk = ~clk;

    tagged_fifo_reg #(.DEPTH(DEPTH)) i_tagged_fifo_reg (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .tx_full(tx_full), .tx_empty(tx_empty),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .ser_rx_eof(ser_rx_eof), .ser_rx_crc_err(ser_rx_crc_err),
        .rx_full(rx_full), .rx_empty(rx_empty),
        .stat_eof(stat_eof), .stat_crc(stat_crc), .stat_ovr(stat_ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_stat(input string req);
        check(req, {29'd0, stat_ovr, stat_crc, stat_eof}, {29'd0, exp_stat});
    endtask

    // Driver: transmit write, expected byte queued when it should be accepted.
    task automatic tx_write(input logic [7:0] b);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = b;
        if (tx_en && txq.size() < DEPTH) txq.push_back(b);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Monitor: serializer pop compared with the scoreboard head.
    task automatic tx_take(input string req);
        logic [7:0] exp;
        @(negedge clk);
        ser_tx_pop = 1'b1;
        #1;
        exp = (txq.size() != 0) ? txq.pop_front() : 8'h00;
        check(req, {24'd0, ser_tx_data}, {24'd0, exp});
        @(negedge clk);
        ser_tx_pop = 1'b0;
    endtask

    // Driver: receive push with tags; model applies drop and lost-data marking.
    task automatic rx_push(input logic [7:0] b, input logic eof, input logic crc);
        @(negedge clk);
        ser_rx_push = 1'b1;
        ser_rx_data = b;
        ser_rx_eof = eof;
        ser_rx_crc_err = crc;
        if (rx_en) begin
            if (rxq.size() < DEPTH) begin
                if (rxq.size() == 0) exp_stat = {1'b0, crc, eof};
                rxq.push_back({1'b0, crc, eof, b});
            end else begin
                rxq[rxq.size()-1][10] = 1'b1;
            end
        end
        @(negedge clk);
        ser_rx_push = 1'b0;
    endtask

    // Monitor: bus read compared with the scoreboard, then the status view.
    task automatic bus_read(input string req);
        logic [7:0] exp;
        @(negedge clk);
        bus_rd = 1'b1;
        #1;
        exp = (rxq.size() != 0) ? rxq[0][7:0] : 8'h00;
        check(req, {24'd0, bus_rdata}, {24'd0, exp});
        if (rxq.size() != 0) begin
            void'(rxq.pop_front());
            if (rxq.size() != 0) exp_stat = rxq[0][10:8];
        end
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        check_stat(req);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {28'd0, tx_empty, tx_full, rx_empty, rx_full}, {28'd0, 4'b1010});
        check_stat("R1");
        rst_n = 1'b1;
        tx_en = 1'b1;
        rx_en = 1'b1;

        // R2 ordering
        tx_write(8'hA5); tx_write(8'h3C); tx_write(8'hF0);
        check("R2", {31'd0, tx_empty}, 32'd0);
        for (int i = 0; i < 3; i++) tx_take("R2");
        #1 check("R2", {31'd0, tx_empty}, 32'd1);
        tx_take("R2");

        // R6 full transmit queue drops the ninth write
        for (int i = 0; i < 9; i++) tx_write(8'(i * 7 + 1));
        #1 check("R6", {31'd0, tx_full}, 32'd1);
        for (int i = 0; i < 9; i++) tx_take("R6");

        // R3 and R4 tags move into status as entries reach the bottom
        rx_push(8'h11, 1'b0, 1'b0);
        rx_push(8'h22, 1'b1, 1'b0);
        rx_push(8'h33, 1'b1, 1'b1);
        #1 check_stat("R4");
        bus_read("R3");
        bus_read("R4");
        // R5 draining keeps the last tags; empty read gives 0
        bus_read("R5");
        bus_read("R5");

        // R7 overrun marks the newest stored entry
        for (int i = 0; i < DEPTH; i++) rx_push(8'(8'h40 + i), 1'b0, 1'(i % 2));
        #1 check("R6", {31'd0, rx_full}, 32'd1);
        rx_push(8'hEE, 1'b1, 1'b1);
        rx_push(8'hEF, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) bus_read("R7");
        #1 check("R7", {31'd0, rx_empty}, 32'd1);

        // R8 enables clear queues and leave status alone
        tx_write(8'h01); tx_write(8'h02);
        @(negedge clk);
        tx_en = 1'b0;
        txq.delete();
        @(negedge clk);
        #1 check("R8", {31'd0, tx_empty}, 32'd1);
        tx_write(8'h55);
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        #1 check("R8", {31'd0, tx_empty}, 32'd1);
        tx_take("R8");

        rx_push(8'h61, 1'b1, 1'b0);
        rx_push(8'h62, 1'b0, 1'b1);
        @(negedge clk);
        rx_en = 1'b0;
        rxq.delete();
        rx_push(8'h63, 1'b1, 1'b1);
        #1 check("R8", {31'd0, rx_empty}, 32'd1);
        check_stat("R8");
        @(negedge clk);
        rx_en = 1'b1;
        bus_read("R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule